// File: doc/BRIEF.md
# Selectable-Rate Multistage Decimation Chain

This block turns a high-rate few-bit delta-sigma stream into 24-bit baseband samples. It produces its own modulator clock enable, which is high on one reference-clock cycle in four. It takes one modulator word on each enabled cycle. The first FIR stage decimates by eight. Five further 4-tap FIR stages follow, and each of them halves the rate again.

A 4-bit select code sets where the output is taken from the cascade. One code therefore sets both the channel response and the output sample rate. The stage at the tap point uses the channel coefficients. These depend on the code and on a clock-family bit. When the programmable-filter enable is set, that stage uses a user coefficient set from a parameter instead. Any change to the configuration clears every delay line and phase counter. No output strobe appears until the newly chosen path holds fresh data.

Top module: `dec_chain`

## Requirements
- R1: `mod_ce_o` is high on exactly one clock out of every four. `mod_dat_i` is taken only on the edge that ends a cycle in which `mod_ce_o` is high.
- R2: The input word is a signed 4-bit value. It is scaled by 2^19. The first stage has 16 taps and decimates by 8, with tap k=0 applied to the newest sample. With `cfg_fam_i`=0 its taps are 1,1,2,2,3,3,3,1,1,3,3,3,2,2,1,1. With `cfg_fam_i`=1 its taps are 1,2,2,2,2,3,3,1,1,3,3,2,2,2,2,1.
- R3: The tap point is chosen from `cfg_sel_i`. Code 9 and codes 10 to 15 take the output after the second stage, so samples are 64 clocks apart. Codes 4 to 8 take it after the fourth stage, 256 clocks apart. Codes 1 to 3 take it after the fifth stage, 512 clocks apart. Code 0 takes it after the sixth stage, 1024 clocks apart.
- R4: Every ÷2 stage has 4 taps. A stage that is not at the tap point uses 4,12,12,4. The tapped stage uses a,16-a,16-a,a, with a = 2 + (code mod 5) + 4·`cfg_fam_i`. Codes above 9 are treated as code 9.
- R5: With `cfg_prog_i`=1 the tapped stage uses the `PROG_TAPS` parameter instead, which defaults to -4,20,20,-4. The tap point does not change.
- R6: Each stage adds up its coefficient·sample products and adds 16. It then shifts the result arithmetically right by 5 and saturates it to the 24-bit signed range.
- R7: `smp_vld_o` is high for exactly one clock per output sample.
- R8: A change of any configuration input discards all stored samples. No output strobe carries data from before the change. The first new strobe comes no earlier than 4·(total decimation to the tap point) clocks after the change.
- R9: While `rst_ni` is low, `smp_vld_o`, `smp_o` and `mod_ce_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_dat_i | input | 4 | Signed modulator word |
| cfg_sel_i | input | 4 | Channel filter select code |
| cfg_prog_i | input | 1 | Use the programmable coefficients in the tapped stage |
| cfg_fam_i | input | 1 | Reference-clock family coefficient choice |
| mod_ce_o | output | 1 | Modulator clock enable (reference ÷4) |
| smp_o | output | 24 | Signed output sample |
| smp_vld_o | output | 1 | One-clock strobe marking a new sample |

## Verification
The bench feeds random modulator words under every tap depth. It compares each sample with a bit-exact model of the cascade, so a wrong coefficient, wrong tap, family or programmable set, or an off-by-one in the rounding shows up as a wrong value. The bench also changes the configuration while samples are in flight. A design that failed to clear its stages would then deliver a stale or mixed sample too early, and that breaks both the latency bound and the value match. Spacing between strobes is measured for each depth. This catches a phase counter that is not reset or a select code that is decoded to the wrong stage, which would show up as the wrong period.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int SEL_W     = 4;
  localparam int CW        = 8;
  localparam int HALF_TAPS = 4;

  // first-stage symmetric taps, half table selected by family
  function automatic logic signed [CW-1:0] s0_coef(input logic fam, input int k, input int taps);
    int m;
    int v;
    m = (k < taps / 2) ? k : taps - 1 - k;
    case (m)
      0:       v = 1;
      1:       v = fam ? 2 : 1;
      2:       v = 2;
      3:       v = 2;
      4:       v = fam ? 2 : 3;
      5:       v = 3;
      6:       v = 3;
      default: v = 1;
    endcase
    return CW'(v);
  endfunction

  function automatic logic [2:0] tap_of(input logic [SEL_W-1:0] sel);
    if (sel >= 4'd9)      return 3'd1;
    else if (sel >= 4'd4) return 3'd3;
    else if (sel >= 4'd1) return 3'd4;
    else                  return 3'd5;
  endfunction

  function automatic logic signed [CW-1:0] ch_coef(input logic [SEL_W-1:0] sel, input logic fam,
                                                   input int k);
    int s;
    int a;
    s = (sel > 4'd9) ? 9 : int'(sel);
    a = 2 + (s % 5) + (fam ? 4 : 0);
    return CW'((k == 0 || k == HALF_TAPS - 1) ? a : 16 - a);
  endfunction

  function automatic logic signed [CW-1:0] mid_coef(input int k);
    return CW'((k == 0 || k == HALF_TAPS - 1) ? 4 : 12);
  endfunction
endpackage

// File: rtl/dec_stage.sv
module dec_stage #(
  parameter int TAPS  = 4,
  parameter int DEC   = 2,
  parameter int DW    = 24,
  parameter int CW    = 8,
  parameter int SHIFT = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] dat_i,
  input  logic [TAPS*CW-1:0]   coef_i,
  output logic                 vld_o,
  output logic signed [DW-1:0] dat_o
);
  localparam int PW = (DEC > 1) ? $clog2(DEC) : 1;
  localparam int FW = $clog2(TAPS + 1);
  localparam int AW = DW + CW + $clog2(TAPS) + 1;
  localparam int HALF = 1 << (SHIFT - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

  logic signed [DW-1:0] line_q [TAPS-1];
  logic [PW-1:0]        ph_q;
  logic [FW-1:0]        fill_q;
  logic signed [CW-1:0] c   [TAPS];
  logic signed [DW-1:0] win [TAPS];
  logic signed [AW-1:0] acc, rnd;
  logic signed [DW-1:0] sat;
  logic                 fire;

  always_comb begin
    win[0] = dat_i;
    for (int k = 1; k < TAPS; k++) win[k] = line_q[k-1];
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      c[k] = coef_i[k*CW +: CW];
      acc  = acc + AW'(win[k]) * AW'(c[k]);
    end
    rnd = (acc + AW'(HALF)) >>> SHIFT;
    if (rnd > MAXV)      sat = MAXV[DW-1:0];
    else if (rnd < MINV) sat = MINV[DW-1:0];
    else                 sat = rnd[DW-1:0];
    fire = vld_i && (ph_q == PW'(DEC - 1)) && (fill_q >= FW'(TAPS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS - 1; k++) line_q[k] <= '0;
      ph_q   <= '0;
      fill_q <= '0;
      vld_o  <= 1'b0;
      dat_o  <= '0;
    end else if (flush_i) begin
      for (int k = 0; k < TAPS - 1; k++) line_q[k] <= '0;
      ph_q   <= '0;
      fill_q <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= fire;
      if (fire) dat_o <= sat;
      if (vld_i) begin
        line_q[0] <= dat_i;
        for (int k = 1; k < TAPS - 1; k++) line_q[k] <= line_q[k-1];
        ph_q <= (ph_q == PW'(DEC - 1)) ? '0 : ph_q + PW'(1);
        if (fill_q < FW'(TAPS - 1)) fill_q <= fill_q + FW'(1);
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R7
  AST_VLD_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> ($past(vld_i) && !$past(flush_i))); // R8
endmodule

// File: rtl/dec_chain.sv
module dec_chain
  import dec_pkg::*;
#(
  parameter int IN_W     = 4,
  parameter int DW       = 24,
  parameter int CE_DIV   = 4,
  parameter int NUM_HALF = 5,
  parameter int S0_TAPS  = 16,
  parameter int S0_DEC   = 8,
  parameter int SHIFT    = 5,
  parameter logic [HALF_TAPS*CW-1:0] PROG_TAPS = {8'hFC, 8'd20, 8'd20, 8'hFC}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IN_W-1:0]      mod_dat_i,
  input  logic [SEL_W-1:0]     cfg_sel_i,
  input  logic                 cfg_prog_i,
  input  logic                 cfg_fam_i,
  output logic                 mod_ce_o,
  output logic signed [DW-1:0] smp_o,
  output logic                 smp_vld_o
);
  localparam int NST   = NUM_HALF + 1;
  localparam int SCALE = DW - IN_W - 1;
  localparam int DVW   = $clog2(CE_DIV);
  localparam int CFW   = SEL_W + 2;
  localparam int CNT_W = 12;

  logic [DVW-1:0]       div_q;
  logic [CFW-1:0]       cfg_q, cfg_d;
  logic                 flush;
  logic [SEL_W-1:0]     sel_q;
  logic                 prog_q, fam_q;
  logic [2:0]           tap_idx;
  logic signed [DW-1:0] in_scaled;
  logic [S0_TAPS*CW-1:0] coef0;
  logic                 s_vld [NST];
  logic signed [DW-1:0] s_dat [NST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= (div_q == DVW'(CE_DIV - 1)) ? '0 : div_q + DVW'(1);
  end
  assign mod_ce_o = (div_q == DVW'(CE_DIV - 1));

  assign cfg_d = {cfg_sel_i, cfg_prog_i, cfg_fam_i};
  assign flush = (cfg_d != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign sel_q   = cfg_q[CFW-1:2];
  assign prog_q  = cfg_q[1];
  assign fam_q   = cfg_q[0];
  assign tap_idx = tap_of(sel_q);

  assign in_scaled = $signed({{(DW-IN_W){mod_dat_i[IN_W-1]}}, mod_dat_i}) <<< SCALE;

  always_comb begin
    for (int k = 0; k < S0_TAPS; k++) coef0[k*CW +: CW] = s0_coef(fam_q, k, S0_TAPS);
  end

  dec_stage #(.TAPS(S0_TAPS), .DEC(S0_DEC), .DW(DW), .CW(CW), .SHIFT(SHIFT)) u_stage0 (
    .clk_i, .rst_ni, .flush_i(flush), .vld_i(mod_ce_o), .dat_i(in_scaled),
    .coef_i(coef0), .vld_o(s_vld[0]), .dat_o(s_dat[0])
  );

  for (genvar g = 1; g < NST; g++) begin : g_half
    logic [HALF_TAPS*CW-1:0] coef;
    always_comb begin
      for (int k = 0; k < HALF_TAPS; k++) begin
        if (tap_idx == 3'(g))
          coef[k*CW +: CW] = prog_q ? PROG_TAPS[k*CW +: CW] : ch_coef(sel_q, fam_q, k);
        else
          coef[k*CW +: CW] = mid_coef(k);
      end
    end
    dec_stage #(.TAPS(HALF_TAPS), .DEC(2), .DW(DW), .CW(CW), .SHIFT(SHIFT)) u_stage (
      .clk_i, .rst_ni, .flush_i(flush), .vld_i(s_vld[g-1]), .dat_i(s_dat[g-1]),
      .coef_i(coef), .vld_o(s_vld[g]), .dat_o(s_dat[g])
    );
  end

  assign smp_vld_o = s_vld[tap_idx];
  assign smp_o     = s_dat[tap_idx];

  // checker: enables accepted since the last flush
  logic [CNT_W-1:0] ce_cnt_q;
  logic [CNT_W-1:0] ratio;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ce_cnt_q <= '0;
    else if (flush)                       ce_cnt_q <= '0;
    else if (mod_ce_o && !(&ce_cnt_q))   ce_cnt_q <= ce_cnt_q + CNT_W'(1);
  end
  assign ratio = CNT_W'(S0_DEC) << tap_idx;

  AST_CE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_ce_o |=> !mod_ce_o ##1 !mod_ce_o ##1 !mod_ce_o ##1 mod_ce_o); // R1
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !smp_vld_o); // R8
  AST_FILL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |-> (ce_cnt_q >= ratio)); // R8
  AST_OUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_o && !flush) |=> !smp_vld_o); // R7
endmodule

// File: tb/dec_chain_bench.sv
module dec_chain_bench;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        mod_dat_i = '0;
  logic [3:0]        cfg_sel_i = '0;
  logic              cfg_prog_i = 1'b0;
  logic              cfg_fam_i = 1'b0;
  logic              mod_ce_o;
  logic signed [23:0] smp_o;
  logic              smp_vld_o;

  dec_chain u_dec_chain (
    .clk_i, .rst_ni, .mod_dat_i, .cfg_sel_i, .cfg_prog_i, .cfg_fam_i,
    .mod_ce_o, .smp_o, .smp_vld_o
  );

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // bench model state
  longint mline [6][16];
  int     mcnt [6];
  longint exp_q [$];
  int     cur_sel = 0, cur_prog = 0, cur_fam = 0;
  int     seg_start = 0, last_cyc = 0, seg_cnt = 0;
  bit     seen_first = 0, prev_vld = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tap_for(input int sel);
    if (sel >= 9) return 1;
    if (sel >= 4) return 3;
    if (sel >= 1) return 4;
    return 5;
  endfunction

  function automatic int ratio_for(input int sel);
    return 8 << tap_for(sel);
  endfunction

  function automatic int bcoef(input int s, input int k);
    int f0 [8] = '{1, 1, 2, 2, 3, 3, 3, 1};
    int f1 [8] = '{1, 2, 2, 2, 2, 3, 3, 1};
    int pt [4] = '{-4, 20, 20, -4};
    int m, a, sc;
    if (s == 0) begin
      m = (k < 8) ? k : 15 - k;
      return cur_fam ? f1[m] : f0[m];
    end
    if (s == tap_for(cur_sel)) begin
      if (cur_prog) return pt[k];
      sc = (cur_sel > 9) ? 9 : cur_sel;
      a = 2 + (sc % 5) + 4 * cur_fam;
      return (k == 0 || k == 3) ? a : 16 - a;
    end
    return (k == 0 || k == 3) ? 4 : 12;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 6; s++) begin
      mcnt[s] = 0;
      for (int k = 0; k < 16; k++) mline[s][k] = 0;
    end
    exp_q.delete();
  endtask

  task automatic model_push(input logic [3:0] w);
    longint v, acc, r;
    int taps, dec, n;
    v = longint'($signed(w)) * 524288;
    for (int s = 0; s < 6; s++) begin
      taps = (s == 0) ? 16 : 4;
      dec  = (s == 0) ? 8 : 2;
      for (int k = taps - 1; k > 0; k--) mline[s][k] = mline[s][k-1];
      mline[s][0] = v;
      n = mcnt[s];
      mcnt[s]++;
      if (!((n % dec == dec - 1) && n >= taps - 1)) break;
      acc = 0;
      for (int k = 0; k < taps; k++) acc += mline[s][k] * bcoef(s, k);
      r = (acc + 16) >>> 5;
      if (r > 8388607) r = 8388607;
      if (r < -8388608) r = -8388608;
      v = r;
      if (s == tap_for(cur_sel)) begin
        exp_q.push_back(r);
        break;
      end
    end
  endtask

  task automatic observe();
    longint e;
    int ratio;
    ratio = ratio_for(cur_sel);
    if (smp_vld_o) begin
      check(!prev_vld, "R7", "strobe width", prev_vld, 0);
      if (!seen_first)
        check(cyc - seg_start >= 4 * ratio, "R8", "fill latency", cyc - seg_start, 4 * ratio);
      else
        check(cyc - last_cyc == 4 * ratio, "R3", "sample spacing", cyc - last_cyc, 4 * ratio);
      if (exp_q.size() == 0) begin
        check(0, "R8", "sample without model output", smp_o, 0);
      end else begin
        e = exp_q.pop_front();
        if (cur_prog) check(smp_o == e, "R5 R6", "sample value", smp_o, e);
        else          check(smp_o == e, "R2 R4 R6", "sample value", smp_o, e);
      end
      seen_first = 1;
      last_cyc = cyc;
      seg_cnt++;
    end
    prev_vld = smp_vld_o;
  endtask

  task automatic tick(input bit do_cfg, input int sel, input int prog, input int fam);
    @(negedge clk_i);
    observe();
    if (do_cfg) begin
      cfg_sel_i = 4'(sel);
      cfg_prog_i = prog[0];
      cfg_fam_i = fam[0];
      cur_sel = sel;
      cur_prog = prog;
      cur_fam = fam;
      model_reset();
      seg_start = cyc;
      seen_first = 0;
      seg_cnt = 0;
    end
    mod_dat_i = 4'($urandom_range(0, 15));
    if (mod_ce_o && !do_cfg) model_push(mod_dat_i);
  endtask

  task automatic run_seg(input int sel, input int prog, input int fam);
    int len;
    len = 40 * ratio_for(sel);
    tick(1, sel, prog, fam);
    for (int i = 0; i < len; i++) tick(0, cur_sel, cur_prog, cur_fam);
    check(seg_cnt >= 4, "R3", "samples per segment", seg_cnt, 4);
  endtask

  initial begin
    int ces, last_ce, s, p, f;
    void'($urandom(32'h1d5e_a7c3));
    model_reset();
    repeat (3) begin
      @(negedge clk_i);
      check(smp_vld_o == 0, "R9", "valid in reset", smp_vld_o, 0);
      check(smp_o == 0 && mod_ce_o == 0, "R9", "outputs in reset", smp_o, 0);
    end
    rst_ni = 1'b1;
    ces = 0;
    last_ce = -1;
    for (int i = 0; i < 40; i++) begin
      tick(0, 0, 0, 0);
      if (mod_ce_o) begin
        if (last_ce >= 0) check(cyc - last_ce == 4, "R1", "enable spacing", cyc - last_ce, 4);
        last_ce = cyc;
        ces++;
      end
    end
    check(ces == 10, "R1", "enable count", ces, 10);
    // directed: each tap depth, both families, programmable, out-of-range code
    run_seg(9, 0, 0);
    run_seg(5, 0, 1);
    run_seg(2, 1, 0);
    run_seg(0, 0, 1);
    run_seg(12, 0, 0);
    run_seg(7, 1, 1);
    for (int i = 0; i < 3; i++) begin
      do begin
        s = $urandom_range(0, 15);
        p = $urandom_range(0, 1);
        f = $urandom_range(0, 1);
      end while (s == cur_sel && p == cur_prog && f == cur_fam);
      run_seg(s, p, f);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule